// File: doc/BRIEF.md
# Store-to-Load Forwarding and Disambiguation Unit

This block sits beside a store queue on the load side of a core's memory pipeline. Each issuing load is compared against the older in-flight stores. When exactly one older store holds every byte the load wants, its bytes are forwarded. When only part of the load's bytes are held, the load is sent down a slow replay path. If a covering store has not yet received its data, the load is told to retry. The unit reports the path taken as a source code and as a latency class. Address translation and the cache array are outside the block. A load that matches no store is simply marked as served by the cache.

The dependency search uses only the page offset, which is the low 12 address bits. A store that sits exactly one 4 KB page away from a load is therefore taken as a dependency. Because the full addresses differ, the load cannot forward and falls onto the slow path. Older stores whose address is still unknown are skipped, so the load runs ahead of them speculatively. Every load that completes without replay is remembered in a small executed-load table. When a store address later resolves, it is checked against the younger loads in that table and against a load issuing in the same cycle. On a real byte overlap, the unit reports a violation carrying the age of the oldest offending load.

Top module: `sfwd_unit`

## Requirements
- R1: A load request produces exactly one response on the next cycle. Cycles without a request produce none. Source codes: 0 = cache, 1 = forwarded, 2 = slow, 3 = wait.
- R2: A load that hits no older store gets source 0, no replay and data zero. Its latency class is 4, or 13 when the load crosses a 64-byte line, meaning the low 6 address bits plus the byte count exceed 64.
- R3: A load fully covered by the selected store, with that store's data present, gets source 1, latency 5 and no replay. Its data is the store's bytes starting at offset (load address − store address), little-endian, with size code s meaning 2^s bytes.
- R4: Among candidate stores, the youngest one that is still older than the load is selected. Stores younger than the load are never candidates. Store A is older than B when the 8-bit difference B−A, read as signed, is positive, so ages may wrap.
- R5: When the selected store overlaps the load only partly, the response is source 2, latency 22 and replay.
- R6: Candidates are found by comparing page offsets only. A store one 4 KB page away from the load, with overlapping offsets, gives source 2, latency 22 and replay.
- R7: When the selected store itself crosses a 64-byte line, the response is source 2, latency 45 and replay, whatever the overlap.
- R8: When the selected store covers the load but has no data yet, the response is source 3, latency 5 and replay.
- R9: An older store whose address has not been written is ignored by the load's search.
- R10: Writing a store's address raises a violation on the next cycle if a younger executed load truly overlaps it (full address). A load issuing in the same cycle also counts. The reported age is the oldest such load.
- R11: After reset, no response and no violation are reported. A freed store no longer takes part in searches, and a freed load no longer takes part in violation checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sq_alloc_vld | input | 1 | Allocate a store entry |
| sq_alloc_idx | input | 3 | Entry being allocated |
| sq_alloc_age | input | 8 | Program-order age of the store |
| sq_addr_vld | input | 1 | Store address write |
| sq_addr_idx | input | 3 | Entry receiving the address |
| sq_addr | input | 48 | Store byte address |
| sq_addr_sz | input | 2 | Store size code |
| sq_data_vld | input | 1 | Store data write |
| sq_data_idx | input | 3 | Entry receiving data |
| sq_data | input | 64 | Store data, byte 0 at the store address |
| sq_free_vld | input | 1 | Release a store entry |
| sq_free_idx | input | 3 | Entry released |
| ld_vld | input | 1 | Load request |
| ld_idx | input | 3 | Executed-load table slot of this load |
| ld_addr | input | 48 | Load byte address |
| ld_sz | input | 2 | Load size code |
| ld_age | input | 8 | Program-order age of the load |
| ld_free_vld | input | 1 | Release an executed-load slot |
| ld_free_idx | input | 3 | Slot released |
| rsp_vld | output | 1 | Response valid |
| rsp_data | output | 64 | Forwarded data (zero otherwise) |
| rsp_src | output | 2 | Source code |
| rsp_lat | output | 6 | Latency class in cycles |
| rsp_replay | output | 1 | Load must be replayed |
| viol_vld | output | 1 | Ordering violation detected |
| viol_age | output | 8 | Age of the oldest violating load |

## Verification
Some rules are checked by the assertions on every cycle. These are the one-cycle pairing of requests and responses, and the fixed pairing of each source code with its latency classes and replay flag. Line-crossing loads must always report the long cache class, and a violation may appear only after a store address write. The bench's scenarios are needed for the rest, because those rules depend on queue contents. That covers which of several stores is selected, including across age wrap, and the forwarded byte values. It also covers the 4 KB false dependency, the store-crossing penalty, and which load age a violation names.

// File: rtl/sfwd_pkg.sv
package sfwd_pkg;
  localparam int unsigned AGE_W      = 8;
  localparam int unsigned LAT_W      = 6;
  localparam int unsigned DATA_W     = 64;
  localparam int unsigned LINE_BYTES = 64;
  localparam int unsigned LINE_OFF_W = $clog2(LINE_BYTES);
  localparam int unsigned PAGE_BITS  = 12;

  typedef enum logic [1:0] {
    SRC_CACHE = 2'd0,
    SRC_FWD   = 2'd1,
    SRC_SLOW  = 2'd2,
    SRC_WAIT  = 2'd3
  } src_e;

  localparam logic [LAT_W-1:0] LAT_HIT         = LAT_W'(4);
  localparam logic [LAT_W-1:0] LAT_LINE_SPLIT  = LAT_W'(13);
  localparam logic [LAT_W-1:0] LAT_FWD         = LAT_W'(5);
  localparam logic [LAT_W-1:0] LAT_PARTIAL     = LAT_W'(22);
  localparam logic [LAT_W-1:0] LAT_SPLIT_STORE = LAT_W'(45);

  function automatic logic [3:0] size_bytes(input logic [1:0] sz);
    return 4'd1 << sz;
  endfunction

  // true when the access runs past the end of its line
  function automatic logic crosses_line(input logic [63:0] a, input logic [1:0] sz);
    logic [LINE_OFF_W:0] last;
    last = {1'b0, a[LINE_OFF_W-1:0]} + (LINE_OFF_W+1)'(size_bytes(sz));
    return last > (LINE_OFF_W+1)'(LINE_BYTES);
  endfunction

  function automatic logic [63:0] page_off(input logic [63:0] a);
    return 64'(a[PAGE_BITS-1:0]);
  endfunction

  function automatic logic spans_overlap(input logic [63:0] a, input logic [1:0] asz,
                                         input logic [63:0] b, input logic [1:0] bsz);
    logic [64:0] a_end, b_end;
    a_end = {1'b0, a} + 65'(size_bytes(asz));
    b_end = {1'b0, b} + 65'(size_bytes(bsz));
    return ({1'b0, a} < b_end) && ({1'b0, b} < a_end);
  endfunction

  // inner span lies entirely within outer span
  function automatic logic span_covers(input logic [63:0] outer, input logic [1:0] osz,
                                       input logic [63:0] inner, input logic [1:0] isz);
    logic [64:0] o_end, i_end;
    o_end = {1'b0, outer} + 65'(size_bytes(osz));
    i_end = {1'b0, inner} + 65'(size_bytes(isz));
    return (inner >= outer) && (i_end <= o_end);
  endfunction

  // wrap-tolerant program order: a is older than b
  function automatic logic age_older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
    logic [AGE_W-1:0] d;
    d = b - a;
    return (d != '0) && !d[AGE_W-1];
  endfunction

  function automatic logic [DATA_W-1:0] extract_bytes(input logic [DATA_W-1:0] d,
                                                      input logic [2:0] off,
                                                      input logic [1:0] sz);
    logic [DATA_W-1:0] sh, mask;
    sh = d >> {off, 3'b000};
    if (sz == 2'd3) mask = '1;
    else            mask = (DATA_W'(1) << {size_bytes(sz), 3'b000}) - DATA_W'(1);
    return sh & mask;
  endfunction
endpackage

// File: rtl/sfwd_store_q.sv
module sfwd_store_q
  import sfwd_pkg::*;
#(
  parameter int unsigned SQ_DEPTH = 8,
  parameter int unsigned ADDR_W   = 48,
  localparam int unsigned IDX_W   = (SQ_DEPTH > 1) ? $clog2(SQ_DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_vld,
  input  logic [IDX_W-1:0]    alloc_idx,
  input  logic [AGE_W-1:0]    alloc_age,
  input  logic                addr_vld,
  input  logic [IDX_W-1:0]    addr_idx,
  input  logic [ADDR_W-1:0]   addr_in,
  input  logic [1:0]          addr_sz,
  input  logic                data_vld,
  input  logic [IDX_W-1:0]    data_idx,
  input  logic [DATA_W-1:0]   data_in,
  input  logic                free_vld,
  input  logic [IDX_W-1:0]    free_idx,
  output logic [SQ_DEPTH-1:0] e_vld,
  output logic [SQ_DEPTH-1:0] e_addr_ok,
  output logic [SQ_DEPTH-1:0] e_data_ok,
  output logic [AGE_W-1:0]    e_age  [SQ_DEPTH],
  output logic [ADDR_W-1:0]   e_addr [SQ_DEPTH],
  output logic [1:0]          e_sz   [SQ_DEPTH],
  output logic [DATA_W-1:0]   e_data [SQ_DEPTH]
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_vld     <= '0;
      e_addr_ok <= '0;
      e_data_ok <= '0;
      for (int i = 0; i < SQ_DEPTH; i++) begin
        e_age[i]  <= '0;
        e_addr[i] <= '0;
        e_sz[i]   <= '0;
        e_data[i] <= '0;
      end
    end else begin
      for (int i = 0; i < SQ_DEPTH; i++) begin
        if (free_vld && free_idx == IDX_W'(i)) begin
          e_vld[i]     <= 1'b0;
          e_addr_ok[i] <= 1'b0;
          e_data_ok[i] <= 1'b0;
        end
        if (alloc_vld && alloc_idx == IDX_W'(i)) begin
          e_vld[i]     <= 1'b1;
          e_age[i]     <= alloc_age;
          e_addr_ok[i] <= 1'b0;
          e_data_ok[i] <= 1'b0;
        end
        if (addr_vld && addr_idx == IDX_W'(i)) begin
          e_addr[i]    <= addr_in;
          e_sz[i]      <= addr_sz;
          e_addr_ok[i] <= 1'b1;
        end
        if (data_vld && data_idx == IDX_W'(i)) begin
          e_data[i]    <= data_in;
          e_data_ok[i] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sfwd_load_pick.sv
module sfwd_load_pick
  import sfwd_pkg::*;
#(
  parameter int unsigned SQ_DEPTH = 8,
  parameter int unsigned ADDR_W   = 48,
  localparam int unsigned IDX_W   = (SQ_DEPTH > 1) ? $clog2(SQ_DEPTH) : 1
) (
  input  logic [ADDR_W-1:0]   ld_addr,
  input  logic [1:0]          ld_sz,
  input  logic [AGE_W-1:0]    ld_age,
  input  logic                ld_split,
  input  logic [SQ_DEPTH-1:0] e_vld,
  input  logic [SQ_DEPTH-1:0] e_addr_ok,
  input  logic [SQ_DEPTH-1:0] e_data_ok,
  input  logic [AGE_W-1:0]    e_age  [SQ_DEPTH],
  input  logic [ADDR_W-1:0]   e_addr [SQ_DEPTH],
  input  logic [1:0]          e_sz   [SQ_DEPTH],
  input  logic [DATA_W-1:0]   e_data [SQ_DEPTH],
  output src_e                pick_src,
  output logic [LAT_W-1:0]    pick_lat,
  output logic                pick_replay,
  output logic [DATA_W-1:0]   pick_data
);
  logic [63:0]         ld_a64;
  logic [SQ_DEPTH-1:0] cand;
  logic                sel_hit;
  logic [IDX_W-1:0]    sel_idx;
  logic [AGE_W-1:0]    best_age;
  logic [63:0]         sel_addr;
  logic                sel_split;
  logic                sel_cover;

  assign ld_a64 = 64'(ld_addr);

  // early search: page offsets only, known addresses, older than the load
  for (genvar g = 0; g < SQ_DEPTH; g++) begin : g_cand
    assign cand[g] = e_vld[g] && e_addr_ok[g] && age_older(e_age[g], ld_age) &&
                     spans_overlap(page_off(64'(e_addr[g])), e_sz[g], page_off(ld_a64), ld_sz);
  end

  always_comb begin
    sel_hit  = 1'b0;
    sel_idx  = '0;
    best_age = '0;
    for (int i = 0; i < SQ_DEPTH; i++) begin
      if (cand[i] && (!sel_hit || age_older(best_age, e_age[i]))) begin
        sel_hit  = 1'b1;
        sel_idx  = IDX_W'(i);
        best_age = e_age[i];
      end
    end
  end

  assign sel_addr  = 64'(e_addr[sel_idx]);
  assign sel_split = sel_hit && crosses_line(sel_addr, e_sz[sel_idx]);
  assign sel_cover = sel_hit && span_covers(sel_addr, e_sz[sel_idx], ld_a64, ld_sz);

  always_comb begin
    pick_src    = SRC_CACHE;
    pick_lat    = ld_split ? LAT_LINE_SPLIT : LAT_HIT;
    pick_replay = 1'b0;
    pick_data   = '0;
    if (sel_hit) begin
      if (sel_split) begin
        pick_src    = SRC_SLOW;
        pick_lat    = LAT_SPLIT_STORE;
        pick_replay = 1'b1;
      end else if (!sel_cover) begin
        pick_src    = SRC_SLOW;
        pick_lat    = LAT_PARTIAL;
        pick_replay = 1'b1;
      end else if (!e_data_ok[sel_idx]) begin
        pick_src    = SRC_WAIT;
        pick_lat    = LAT_FWD;
        pick_replay = 1'b1;
      end else begin
        pick_src  = SRC_FWD;
        pick_lat  = LAT_FWD;
        pick_data = extract_bytes(e_data[sel_idx], 3'(ld_a64 - sel_addr), ld_sz);
      end
    end
  end
endmodule

// File: rtl/sfwd_alias_watch.sv
module sfwd_alias_watch
  import sfwd_pkg::*;
#(
  parameter int unsigned LT_DEPTH = 8,
  parameter int unsigned ADDR_W   = 48,
  localparam int unsigned IDX_W   = (LT_DEPTH > 1) ? $clog2(LT_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_vld,
  input  logic [IDX_W-1:0]  rec_idx,
  input  logic [ADDR_W-1:0] rec_addr,
  input  logic [1:0]        rec_sz,
  input  logic [AGE_W-1:0]  rec_age,
  input  logic              ret_vld,
  input  logic [IDX_W-1:0]  ret_idx,
  input  logic              chk_vld,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [1:0]        chk_sz,
  input  logic [AGE_W-1:0]  chk_age,
  output logic              viol_hit,
  output logic              viol_vld,
  output logic [AGE_W-1:0]  viol_age
);
  logic [LT_DEPTH-1:0] t_vld;
  logic [ADDR_W-1:0]   t_addr [LT_DEPTH];
  logic [1:0]          t_sz   [LT_DEPTH];
  logic [AGE_W-1:0]    t_age  [LT_DEPTH];
  logic [LT_DEPTH-1:0] hit;
  logic                cur_hit;
  logic [AGE_W-1:0]    oldest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_vld <= '0;
      for (int i = 0; i < LT_DEPTH; i++) begin
        t_addr[i] <= '0;
        t_sz[i]   <= '0;
        t_age[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < LT_DEPTH; i++) begin
        if (ret_vld && ret_idx == IDX_W'(i)) t_vld[i] <= 1'b0;
        if (rec_vld && rec_idx == IDX_W'(i)) begin
          t_vld[i]  <= 1'b1;
          t_addr[i] <= rec_addr;
          t_sz[i]   <= rec_sz;
          t_age[i]  <= rec_age;
        end
      end
    end
  end

  for (genvar g = 0; g < LT_DEPTH; g++) begin : g_hit
    assign hit[g] = t_vld[g] && age_older(chk_age, t_age[g]) &&
                    spans_overlap(64'(chk_addr), chk_sz, 64'(t_addr[g]), t_sz[g]);
  end

  // a load issuing alongside the address write bypassed the store too
  assign cur_hit = rec_vld && age_older(chk_age, rec_age) &&
                   spans_overlap(64'(chk_addr), chk_sz, 64'(rec_addr), rec_sz);

  always_comb begin
    oldest = rec_age;
    for (int i = 0; i < LT_DEPTH; i++) begin
      if (hit[i] && (!cur_hit || age_older(t_age[i], oldest))) oldest = t_age[i];
    end
    for (int i = 0; i < LT_DEPTH; i++) begin
      if (hit[i] && age_older(t_age[i], oldest)) oldest = t_age[i];
    end
  end

  assign viol_hit = chk_vld && ((|hit) || cur_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_vld <= 1'b0;
      viol_age <= '0;
    end else begin
      viol_vld <= viol_hit;
      viol_age <= viol_hit ? oldest : '0;
    end
  end
endmodule

// File: rtl/sfwd_unit.sv
module sfwd_unit
  import sfwd_pkg::*;
#(
  parameter int unsigned SQ_DEPTH = 8,
  parameter int unsigned LT_DEPTH = 8,
  parameter int unsigned ADDR_W   = 48,
  localparam int unsigned SQ_IDX_W = (SQ_DEPTH > 1) ? $clog2(SQ_DEPTH) : 1,
  localparam int unsigned LT_IDX_W = (LT_DEPTH > 1) ? $clog2(LT_DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sq_alloc_vld,
  input  logic [SQ_IDX_W-1:0] sq_alloc_idx,
  input  logic [AGE_W-1:0]    sq_alloc_age,
  input  logic                sq_addr_vld,
  input  logic [SQ_IDX_W-1:0] sq_addr_idx,
  input  logic [ADDR_W-1:0]   sq_addr,
  input  logic [1:0]          sq_addr_sz,
  input  logic                sq_data_vld,
  input  logic [SQ_IDX_W-1:0] sq_data_idx,
  input  logic [DATA_W-1:0]   sq_data,
  input  logic                sq_free_vld,
  input  logic [SQ_IDX_W-1:0] sq_free_idx,
  input  logic                ld_vld,
  input  logic [LT_IDX_W-1:0] ld_idx,
  input  logic [ADDR_W-1:0]   ld_addr,
  input  logic [1:0]          ld_sz,
  input  logic [AGE_W-1:0]    ld_age,
  input  logic                ld_free_vld,
  input  logic [LT_IDX_W-1:0] ld_free_idx,
  output logic                rsp_vld,
  output logic [DATA_W-1:0]   rsp_data,
  output logic [1:0]          rsp_src,
  output logic [LAT_W-1:0]    rsp_lat,
  output logic                rsp_replay,
  output logic                viol_vld,
  output logic [AGE_W-1:0]    viol_age
);
  logic [SQ_DEPTH-1:0] e_vld, e_addr_ok, e_data_ok;
  logic [AGE_W-1:0]    e_age  [SQ_DEPTH];
  logic [ADDR_W-1:0]   e_addr [SQ_DEPTH];
  logic [1:0]          e_sz   [SQ_DEPTH];
  logic [DATA_W-1:0]   e_data [SQ_DEPTH];

  // named events for the checker
  logic             ld_split;
  src_e             pick_src;
  logic [LAT_W-1:0] pick_lat;
  logic             pick_replay;
  logic [DATA_W-1:0] pick_data;
  logic             ld_record;
  logic             viol_hit;

  assign ld_split  = crosses_line(64'(ld_addr), ld_sz);
  assign ld_record = ld_vld && !pick_replay;

  sfwd_store_q #(.SQ_DEPTH(SQ_DEPTH), .ADDR_W(ADDR_W)) i_sq (
    .clk(clk), .rst_n(rst_n),
    .alloc_vld(sq_alloc_vld), .alloc_idx(sq_alloc_idx), .alloc_age(sq_alloc_age),
    .addr_vld(sq_addr_vld), .addr_idx(sq_addr_idx), .addr_in(sq_addr), .addr_sz(sq_addr_sz),
    .data_vld(sq_data_vld), .data_idx(sq_data_idx), .data_in(sq_data),
    .free_vld(sq_free_vld), .free_idx(sq_free_idx),
    .e_vld(e_vld), .e_addr_ok(e_addr_ok), .e_data_ok(e_data_ok),
    .e_age(e_age), .e_addr(e_addr), .e_sz(e_sz), .e_data(e_data)
  );

  sfwd_load_pick #(.SQ_DEPTH(SQ_DEPTH), .ADDR_W(ADDR_W)) i_pick (
    .ld_addr(ld_addr), .ld_sz(ld_sz), .ld_age(ld_age), .ld_split(ld_split),
    .e_vld(e_vld), .e_addr_ok(e_addr_ok), .e_data_ok(e_data_ok),
    .e_age(e_age), .e_addr(e_addr), .e_sz(e_sz), .e_data(e_data),
    .pick_src(pick_src), .pick_lat(pick_lat), .pick_replay(pick_replay), .pick_data(pick_data)
  );

  sfwd_alias_watch #(.LT_DEPTH(LT_DEPTH), .ADDR_W(ADDR_W)) i_watch (
    .clk(clk), .rst_n(rst_n),
    .rec_vld(ld_record), .rec_idx(ld_idx), .rec_addr(ld_addr), .rec_sz(ld_sz), .rec_age(ld_age),
    .ret_vld(ld_free_vld), .ret_idx(ld_free_idx),
    .chk_vld(sq_addr_vld), .chk_addr(sq_addr), .chk_sz(sq_addr_sz), .chk_age(e_age[sq_addr_idx]),
    .viol_hit(viol_hit), .viol_vld(viol_vld), .viol_age(viol_age)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld    <= 1'b0;
      rsp_data   <= '0;
      rsp_src    <= 2'(SRC_CACHE);
      rsp_lat    <= '0;
      rsp_replay <= 1'b0;
    end else begin
      rsp_vld    <= ld_vld;
      rsp_data   <= ld_vld ? pick_data : '0;
      rsp_src    <= ld_vld ? 2'(pick_src) : 2'(SRC_CACHE);
      rsp_lat    <= ld_vld ? pick_lat : '0;
      rsp_replay <= ld_vld && pick_replay;
    end
  end
endmodule

// File: rtl/sfwd_checker.sv
module sfwd_checker
  import sfwd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ld_vld,
  input logic             ld_split,
  input logic             sq_addr_vld,
  input logic             viol_hit,
  input logic             rsp_vld,
  input logic [1:0]       rsp_src,
  input logic [LAT_W-1:0] rsp_lat,
  input logic             rsp_replay,
  input logic             viol_vld
);
  p_rsp_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_vld |=> rsp_vld);
  p_rsp_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_vld |=> !rsp_vld);
  p_cache_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_src == 2'(SRC_CACHE)) |-> (!rsp_replay && (rsp_lat == LAT_HIT || rsp_lat == LAT_LINE_SPLIT)));
  p_split_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_vld && ld_split) |=> (rsp_src != 2'(SRC_CACHE) || rsp_lat == LAT_LINE_SPLIT));
  p_fwd_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_src == 2'(SRC_FWD)) |-> (rsp_lat == LAT_FWD && !rsp_replay));
  p_slow_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_src == 2'(SRC_SLOW)) |-> (rsp_replay && (rsp_lat == LAT_PARTIAL || rsp_lat == LAT_SPLIT_STORE)));
  p_wait_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_src == 2'(SRC_WAIT)) |-> (rsp_replay && rsp_lat == LAT_FWD));
  p_viol_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    viol_vld |-> $past(sq_addr_vld));
  p_viol_timing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    viol_hit |=> viol_vld);
endmodule

bind sfwd_unit sfwd_checker i_sfwd_checker (
  .clk(clk), .rst_n(rst_n), .ld_vld(ld_vld), .ld_split(ld_split),
  .sq_addr_vld(sq_addr_vld), .viol_hit(viol_hit),
  .rsp_vld(rsp_vld), .rsp_src(rsp_src), .rsp_lat(rsp_lat), .rsp_replay(rsp_replay),
  .viol_vld(viol_vld)
);

// File: tb/test_sfwd_unit.sv
module test_sfwd_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sq_alloc_vld = 0; logic [2:0] sq_alloc_idx = 0; logic [7:0] sq_alloc_age = 0;
  logic        sq_addr_vld = 0;  logic [2:0] sq_addr_idx = 0;  logic [47:0] sq_addr = 0; logic [1:0] sq_addr_sz = 0;
  logic        sq_data_vld = 0;  logic [2:0] sq_data_idx = 0;  logic [63:0] sq_data = 0;
  logic        sq_free_vld = 0;  logic [2:0] sq_free_idx = 0;
  logic        ld_vld = 0; logic [2:0] ld_idx = 0; logic [47:0] ld_addr = 0; logic [1:0] ld_sz = 0; logic [7:0] ld_age = 0;
  logic        ld_free_vld = 0; logic [2:0] ld_free_idx = 0;
  logic        rsp_vld; logic [63:0] rsp_data; logic [1:0] rsp_src; logic [5:0] rsp_lat; logic rsp_replay;
  logic        viol_vld; logic [7:0] viol_age;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sfwd_unit i_sfwd_unit (
    .clk(clk), .rst_n(rst_n),
    .sq_alloc_vld(sq_alloc_vld), .sq_alloc_idx(sq_alloc_idx), .sq_alloc_age(sq_alloc_age),
    .sq_addr_vld(sq_addr_vld), .sq_addr_idx(sq_addr_idx), .sq_addr(sq_addr), .sq_addr_sz(sq_addr_sz),
    .sq_data_vld(sq_data_vld), .sq_data_idx(sq_data_idx), .sq_data(sq_data),
    .sq_free_vld(sq_free_vld), .sq_free_idx(sq_free_idx),
    .ld_vld(ld_vld), .ld_idx(ld_idx), .ld_addr(ld_addr), .ld_sz(ld_sz), .ld_age(ld_age),
    .ld_free_vld(ld_free_vld), .ld_free_idx(ld_free_idx),
    .rsp_vld(rsp_vld), .rsp_data(rsp_data), .rsp_src(rsp_src), .rsp_lat(rsp_lat),
    .rsp_replay(rsp_replay), .viol_vld(viol_vld), .viol_age(viol_age)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  task automatic st_alloc(input logic [2:0] idx, input logic [7:0] age);
    @(negedge clk); sq_alloc_vld = 1; sq_alloc_idx = idx; sq_alloc_age = age;
    @(negedge clk); sq_alloc_vld = 0;
  endtask

  task automatic st_addr(input logic [2:0] idx, input logic [47:0] a, input logic [1:0] sz);
    @(negedge clk); sq_addr_vld = 1; sq_addr_idx = idx; sq_addr = a; sq_addr_sz = sz;
    @(negedge clk); sq_addr_vld = 0;
  endtask

  task automatic st_data(input logic [2:0] idx, input logic [63:0] d);
    @(negedge clk); sq_data_vld = 1; sq_data_idx = idx; sq_data = d;
    @(negedge clk); sq_data_vld = 0;
  endtask

  task automatic st_full(input logic [2:0] idx, input logic [7:0] age, input logic [47:0] a,
                         input logic [1:0] sz, input logic [63:0] d);
    st_alloc(idx, age); st_addr(idx, a, sz); st_data(idx, d);
  endtask

  task automatic st_free(input logic [2:0] idx);
    @(negedge clk); sq_free_vld = 1; sq_free_idx = idx;
    @(negedge clk); sq_free_vld = 0;
  endtask

  task automatic lq_free(input logic [2:0] idx);
    @(negedge clk); ld_free_vld = 1; ld_free_idx = idx;
    @(negedge clk); ld_free_vld = 0;
  endtask

  // issue at a falling edge; the registered response is read at the next one
  task automatic load(input logic [2:0] idx, input logic [47:0] a, input logic [1:0] sz, input logic [7:0] age);
    @(negedge clk); ld_vld = 1; ld_idx = idx; ld_addr = a; ld_sz = sz; ld_age = age;
    @(negedge clk); ld_vld = 0;
  endtask

  task automatic expect_rsp(input string req, input logic [1:0] src, input logic [5:0] lat,
                            input logic rep, input logic [63:0] data);
    chk(req, "rsp_vld", 64'(rsp_vld), 64'(1'b1));
    chk(req, "rsp_src", 64'(rsp_src), 64'(src));
    chk(req, "rsp_lat", 64'(rsp_lat), 64'(lat));
    chk(req, "rsp_replay", 64'(rsp_replay), 64'(rep));
    chk(req, "rsp_data", rsp_data, data);
  endtask

  task automatic t_reset();
    chk("R11", "rsp_vld after reset", 64'(rsp_vld), 0);
    chk("R11", "viol_vld after reset", 64'(viol_vld), 0);
    @(negedge clk);
    chk("R1", "no response without request", 64'(rsp_vld), 0);
  endtask

  task automatic t_cache();
    load(3'd0, 48'h1000_0040, 2'd3, 8'd5);
    expect_rsp("R2 plain", 2'd0, 6'd4, 1'b0, 64'h0);
    load(3'd0, 48'h1000_003C, 2'd3, 8'd5);   // 0x3C+8 > 64
    expect_rsp("R2 line-crossing", 2'd0, 6'd13, 1'b0, 64'h0);
    load(3'd0, 48'h1000_0038, 2'd3, 8'd5);   // ends exactly at 64
    expect_rsp("R2 line end", 2'd0, 6'd4, 1'b0, 64'h0);
  endtask

  task automatic t_forward();
    st_full(3'd0, 8'd10, 48'h2000_0100, 2'd3, 64'h8877_6655_4433_2211);
    load(3'd0, 48'h2000_0102, 2'd1, 8'd20);
    expect_rsp("R3 offset 2", 2'd1, 6'd5, 1'b0, 64'h4433);
    load(3'd0, 48'h2000_0100, 2'd3, 8'd20);
    expect_rsp("R3 full width", 2'd1, 6'd5, 1'b0, 64'h8877_6655_4433_2211);
  endtask

  task automatic t_youngest();
    st_full(3'd1, 8'd12, 48'h2000_0100, 2'd2, 64'h0000_0000_AABB_CCDD);
    load(3'd0, 48'h2000_0100, 2'd2, 8'd20);
    expect_rsp("R4 youngest older", 2'd1, 6'd5, 1'b0, 64'hAABB_CCDD);
    load(3'd0, 48'h2000_0100, 2'd2, 8'd11);
    expect_rsp("R4 younger store skipped", 2'd1, 6'd5, 1'b0, 64'h4433_2211);
    st_free(3'd1);
    load(3'd0, 48'h2000_0100, 2'd2, 8'd20);
    expect_rsp("R11 freed store", 2'd1, 6'd5, 1'b0, 64'h4433_2211);
    st_free(3'd0);
  endtask

  task automatic t_wrap();
    st_full(3'd0, 8'd250, 48'h2000_0200, 2'd3, 64'h0102_0304_0506_0708);
    load(3'd0, 48'h2000_0204, 2'd2, 8'd3);
    expect_rsp("R4 age wrap", 2'd1, 6'd5, 1'b0, 64'h0102_0304);
    load(3'd0, 48'h2000_0204, 2'd2, 8'd240);
    expect_rsp("R4 store younger", 2'd0, 6'd4, 1'b0, 64'h0);
    st_free(3'd0);
  endtask

  task automatic t_partial_alias();
    st_full(3'd0, 8'd30, 48'h3000_0004, 2'd2, 64'h1111_2222);
    load(3'd0, 48'h3000_0000, 2'd3, 8'd40);
    expect_rsp("R5 partial", 2'd2, 6'd22, 1'b1, 64'h0);
    st_free(3'd0);
    st_full(3'd1, 8'd31, 48'h3000_0000, 2'd3, 64'h5555_6666_7777_8888);
    load(3'd0, 48'h3000_1000, 2'd3, 8'd40);
    expect_rsp("R6 4K alias", 2'd2, 6'd22, 1'b1, 64'h0);
    load(3'd0, 48'h3000_2008, 2'd3, 8'd40);
    expect_rsp("R6 adjacent offset no match", 2'd0, 6'd4, 1'b0, 64'h0);
    st_free(3'd1);
  endtask

  task automatic t_split_wait();
    st_full(3'd2, 8'd33, 48'h4000_003C, 2'd3, 64'hDEAD_BEEF_0000_0001);
    load(3'd0, 48'h4000_003C, 2'd2, 8'd41);
    expect_rsp("R7 crossing store", 2'd2, 6'd45, 1'b1, 64'h0);
    st_free(3'd2);
    st_alloc(3'd3, 8'd34);
    st_addr(3'd3, 48'h4000_0080, 2'd3);
    load(3'd0, 48'h4000_0080, 2'd3, 8'd42);
    expect_rsp("R8 data missing", 2'd3, 6'd5, 1'b1, 64'h0);
    st_data(3'd3, 64'h1122_3344_5566_7788);
    load(3'd0, 48'h4000_0080, 2'd3, 8'd42);
    expect_rsp("R8 data arrived", 2'd1, 6'd5, 1'b0, 64'h1122_3344_5566_7788);
    st_free(3'd3);
  endtask

  task automatic t_bypass_violation();
    st_alloc(3'd4, 8'd60);
    load(3'd3, 48'h5000_0000, 2'd3, 8'd72);
    expect_rsp("R9 unknown address bypassed", 2'd0, 6'd4, 1'b0, 64'h0);
    load(3'd2, 48'h5000_0000, 2'd3, 8'd70);
    expect_rsp("R9 second bypass", 2'd0, 6'd4, 1'b0, 64'h0);
    load(3'd1, 48'h5000_0000, 2'd3, 8'd55);
    expect_rsp("R9 older load", 2'd0, 6'd4, 1'b0, 64'h0);
    st_addr(3'd4, 48'h5000_0004, 2'd2);
    chk("R10", "viol_vld", 64'(viol_vld), 1);
    chk("R10", "viol_age oldest", 64'(viol_age), 64'd70);
    @(negedge clk);
    chk("R10", "viol_vld one cycle", 64'(viol_vld), 0);
    st_alloc(3'd5, 8'd61);
    st_addr(3'd5, 48'h5000_0100, 2'd3);
    chk("R10", "no overlap no violation", 64'(viol_vld), 0);
    lq_free(3'd3);
    lq_free(3'd2);
    st_alloc(3'd6, 8'd62);
    st_addr(3'd6, 48'h5000_0000, 2'd3);
    chk("R11", "freed loads ignored", 64'(viol_vld), 0);
    st_free(3'd4); st_free(3'd5); st_free(3'd6);
    st_alloc(3'd7, 8'd63);
    @(negedge clk);
    sq_addr_vld = 1; sq_addr_idx = 3'd7; sq_addr = 48'h6000_0000; sq_addr_sz = 2'd3;
    ld_vld = 1; ld_idx = 3'd4; ld_addr = 48'h6000_0000; ld_sz = 2'd3; ld_age = 8'd90;
    @(negedge clk);
    sq_addr_vld = 0; ld_vld = 0;
    expect_rsp("R9 same-cycle address", 2'd0, 6'd4, 1'b0, 64'h0);
    chk("R10", "same-cycle violation", 64'(viol_vld), 1);
    chk("R10", "same-cycle viol_age", 64'(viol_age), 64'd90);
    st_free(3'd7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cache();
    t_forward();
    t_youngest();
    t_wrap();
    t_partial_alias();
    t_split_wait();
    t_bypass_violation();
    done = 1;
    summary();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
    end
  end
endmodule